// File: doc/BRIEF.md
# Byte-wide SPI controller with sequenced status flags

This block is a byte-wide SPI peripheral that works as master or slave in mode 0. Clock idles low, data is sampled on the rising edge and changed on the falling edge, and bits go out most significant bit first. Software drives it through a small synchronous register bus that has a control register, a status/configuration register and a data register. In master mode, writing the data register loads the shift register and starts an exchange. The shift clock comes from a power-of-two divider of the system clock. Each received byte is copied into a holding buffer, and data reads return that buffer, never the live shift register.

Four status flags report transfer complete, write collision, overrun and master mode fault. Each flag clears only through its own ordered sequence of register accesses. While transfer complete is pending and has not yet been seen through a status read, data writes are dropped. Software can switch off the serial data output. The slave select can come from the pin or from a software-held level. One interrupt line merges the flags that request service.

Register map: address 0 is control, address 1 is status, address 2 is data, and address 3 reads 0. Control bits: 7 is interrupt enable, 6 is block enable, 4 is master select, and 1:0 is the rate code. Control reads return 0 in bits 5, 3 and 2. Status bits: 7 is transfer complete, 6 is write collision, 5 is overrun, 4 is mode fault, 3 reads 0, 2 is output disable, 1 is select-by-software and 0 is the software select level. Only bits 2:0 of status are writable.

Top module: `spi_ctlr`

## Requirements
- R1: After reset, control reads 00h, status reads 00h, irq is 0, and sck_oe, mosi_oe and miso_oe are 0.
- R2: With block enable and master select set, a data write starts an 8-bit mode-0 exchange, MSB first. The SCK half period is 2<<rate system clocks. At the end, transfer complete (status bit 7) is set, and a data read returns the byte received on miso_i.
- R3: Transfer complete clears after a status read, made while it is set, followed by a data read or data write. A data write made while it is set, without that prior status read, is dropped: no transfer starts.
- R4: A data write while a byte is being shifted sets write collision (status bit 6) and leaves the outgoing byte unchanged. The flag clears after a status read, made while it is set, followed by a data read.
- R5: When a byte completes while transfer complete is still set, overrun (status bit 5) is set. The buffer keeps the earlier byte and the new byte is lost. Overrun clears on a status read.
- R6: When the block is enabled as master and the internal select is low, mode fault (status bit 4) is set. Block enable and master select are cleared, which releases sck_oe and mosi_oe.
- R7: Mode fault clears only when a status read made while it is set is followed by a control write. A control write with no such prior status read leaves it set.
- R8: Output disable (status bit 2) holds mosi_oe and miso_oe at 0 while the clock output stays enabled.
- R9: When select-by-software (status bit 1) is 1, the internal select equals the software level (status bit 0; 0 selects) and ss_n_i is ignored. Otherwise the internal select is ss_n_i after two-stage synchronisation.
- R10: When enabled as a selected slave, the block samples mosi_i on rising sck_i, presents the loaded byte MSB first on miso_o with miso_oe 1, and sets transfer complete after 8 bits.
- R11: irq is 1 exactly when interrupt enable is set and at least one of transfer complete, overrun or mode fault is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during the read strobe cycle |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master-out line in (slave) |
| mosi_o | output | 1 | Master-out line out |
| mosi_oe | output | 1 | Master-out output enable |
| miso_i | input | 1 | Master-in line in (master) |
| miso_o | output | 1 | Master-in line out |
| miso_oe | output | 1 | Master-in output enable |
| ss_n_i | input | 1 | Slave select pin, active low |
| irq | output | 1 | Interrupt request |

## Verification
Read data is combinational, so it is sampled in the strobe cycle itself. A register write becomes visible from the cycle after its strobe, and the bench always reads at least one cycle later. A master transfer sets transfer complete about 16*(2<<rate)+2 cycles after the data write. The bench waits for irq with a bounded poll rather than counting an exact cycle. For slave traffic and for mode faults, the pin passes two synchroniser stages and one flag register, so results are due within three cycles. The bench keeps at least ten cycles between pin changes and samples only after that margin. A dropped write is checked by holding sck_o under watch for many divider periods.

// File: rtl/spi_ctlr_pkg.sv
// Package: shared constants of the SPI controller.
// Assumes an 8-bit register bus and an 8-bit serial byte.
package spi_ctlr_pkg;
    localparam int DATA_W      = 8;
    localparam int RATE_W      = 2;
    localparam int ADDR_W      = 2;
    localparam int SYNC_STAGES = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

    // control register bit positions
    localparam int C_IE   = 7;
    localparam int C_EN   = 6;
    localparam int C_MSTR = 4;
endpackage

// File: rtl/spi_ctlr_clkdiv.sv
// Module: shift clock divider.
// Produces a one-cycle tick every (2 << rate) system clocks while run is high.
// Assumes that rate changes only while run is low.
module spi_ctlr_clkdiv #(
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int CNT_W = (1 << RATE_W) + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half;

    // half-period length from the rate code
    always_comb begin
        half = {{(CNT_W-2){1'b0}}, 2'b10} << rate;
        tick = run && (cnt == half - 1'b1);
    end

    // free-running count, restarted whenever the divider is idle
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spi_ctlr_shifter.sv
// Module: mode-0 serial shift engine.
// Master: driven by divider ticks, it samples miso on the rising edge and
// shifts on the falling edge. Slave: it follows the synchronised sck.
// Emits a one-cycle done pulse with the received byte.
// Assumes that load is asserted only while busy is low.
module spi_ctlr_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              mstr,
    input  logic              sel,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              miso_i,
    input  logic              sck_s,
    input  logic              mosi_s,
    output logic              sck_o,
    output logic              sdo,
    output logic              mbusy,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_data
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  bitcnt;
    logic              rx_bit;
    logic              sact;
    logic              sck_prev;
    logic              sck_rise;
    logic              sck_fall;

    // slave clock edges and output views
    always_comb begin
        sck_rise = sck_s && !sck_prev;
        sck_fall = !sck_s && sck_prev;
        sdo      = shreg[DATA_W-1];
        busy     = mbusy || sact;
    end

    // edge history of the synchronised slave clock
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck_s;
    end

    // shift sequencing for both roles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0; bitcnt <= '0; rx_bit <= 1'b0; sck_o <= 1'b0;
            mbusy <= 1'b0; sact <= 1'b0; done <= 1'b0; rx_data <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                shreg  <= load_data;
                bitcnt <= '0;
                sck_o  <= 1'b0;
                mbusy  <= en && mstr;
                sact   <= 1'b0;
            end else if (en && mstr) begin
                if (mbusy && tick) begin
                    if (!sck_o) begin
                        sck_o  <= 1'b1;
                        rx_bit <= miso_i;
                    end else begin
                        sck_o  <= 1'b0;
                        shreg  <= {shreg[DATA_W-2:0], rx_bit};
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == LAST) begin
                            mbusy   <= 1'b0;
                            done    <= 1'b1;
                            rx_data <= {shreg[DATA_W-2:0], rx_bit};
                        end
                    end
                end
            end else if (en && sel) begin
                mbusy <= 1'b0;
                sck_o <= 1'b0;
                if (sck_rise) begin
                    rx_bit <= mosi_s;
                    sact   <= 1'b1;
                end else if (sck_fall && sact) begin
                    shreg  <= {shreg[DATA_W-2:0], rx_bit};
                    bitcnt <= bitcnt + 1'b1;
                    if (bitcnt == LAST) begin
                        sact    <= 1'b0;
                        done    <= 1'b1;
                        rx_data <= {shreg[DATA_W-2:0], rx_bit};
                    end
                end
            end else begin
                mbusy  <= 1'b0;
                sact   <= 1'b0;
                bitcnt <= '0;
                sck_o  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spi_ctlr_regs.sv
// Module: register file, status flags and their clearing sequences.
// Decodes bus accesses, holds the receive buffer, and issues shift-register
// loads. Assumes one strobe per cycle, and that rd and wr are never both
// high in the same cycle.
module spi_ctlr_regs #(
    parameter int DATA_W = 8,
    parameter int RATE_W = 2,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              done,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              busy,
    input  logic              ss_pin_s,
    output logic              ie,
    output logic              en,
    output logic              mstr,
    output logic [RATE_W-1:0] rate,
    output logic              sod,
    output logic              ss_int,
    output logic              spif,
    output logic              wcol,
    output logic              ovr,
    output logic              modf,
    output logic              load,
    output logic [DATA_W-1:0] load_data
);
    import spi_ctlr_pkg::*;

    logic              ssm, ssi;
    logic              spif_arm, wcol_arm, modf_arm;
    logic [DATA_W-1:0] rbuf;
    logic              fault, stat_rd, ctrl_wr, stat_wr, data_rd, dwr;
    logic              locked, spif_clr, wcol_clr, modf_clr, keep_old;

    // access decode and flag-sequence conditions
    always_comb begin
        ss_int    = ssm ? ssi : ss_pin_s;
        fault     = en && mstr && !ss_int;
        stat_rd   = bus_rd && (bus_addr == A_STAT);
        stat_wr   = bus_wr && (bus_addr == A_STAT);
        ctrl_wr   = bus_wr && (bus_addr == A_CTRL);
        data_rd   = bus_rd && (bus_addr == A_DATA);
        dwr       = bus_wr && (bus_addr == A_DATA);
        locked    = spif && !spif_arm;
        spif_clr  = (data_rd || dwr) && spif_arm;
        wcol_clr  = data_rd && wcol_arm;
        modf_clr  = ctrl_wr && modf_arm;
        keep_old  = spif && !spif_clr;
        load      = dwr && !locked && !busy;
        load_data = bus_wdata;
    end

    // read data multiplexer
    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = {ie, en, 1'b0, mstr, 2'b00, rate};
            A_STAT:  bus_rdata = {spif, wcol, ovr, modf, 1'b0, sod, ssm, ssi};
            A_DATA:  bus_rdata = rbuf;
            default: bus_rdata = '0;
        endcase
    end

    // control register; a mode fault drops enable and master select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie <= 1'b0; en <= 1'b0; mstr <= 1'b0; rate <= '0;
        end else begin
            if (ctrl_wr) begin
                ie   <= bus_wdata[C_IE];
                en   <= bus_wdata[C_EN];
                mstr <= bus_wdata[C_MSTR];
                rate <= bus_wdata[RATE_W-1:0];
            end
            if (fault) begin
                en   <= 1'b0;
                mstr <= 1'b0;
            end
        end
    end

    // writable configuration bits of the status register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sod <= 1'b0; ssm <= 1'b0; ssi <= 1'b0;
        end else if (stat_wr) begin
            sod <= bus_wdata[2];
            ssm <= bus_wdata[1];
            ssi <= bus_wdata[0];
        end
    end

    // transfer-complete flag, its arm bit, overrun and the receive buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spif <= 1'b0; spif_arm <= 1'b0; ovr <= 1'b0; rbuf <= '0;
        end else begin
            if (done)          spif <= 1'b1;
            else if (spif_clr) spif <= 1'b0;

            if (spif_clr)             spif_arm <= 1'b0;
            else if (stat_rd && spif) spif_arm <= 1'b1;

            if (done && keep_old) ovr <= 1'b1;
            else if (stat_rd)     ovr <= 1'b0;

            if (done && !keep_old) rbuf <= rx_data;
        end
    end

    // write-collision flag and its arm bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcol <= 1'b0; wcol_arm <= 1'b0;
        end else begin
            if (dwr && !locked && busy) wcol <= 1'b1;
            else if (wcol_clr)          wcol <= 1'b0;

            if (wcol_clr)             wcol_arm <= 1'b0;
            else if (stat_rd && wcol) wcol_arm <= 1'b1;
        end
    end

    // mode-fault flag and its arm bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            modf <= 1'b0; modf_arm <= 1'b0;
        end else begin
            if (fault)         modf <= 1'b1;
            else if (modf_clr) modf <= 1'b0;

            if (modf_clr)             modf_arm <= 1'b0;
            else if (stat_rd && modf) modf_arm <= 1'b1;
        end
    end
endmodule

// File: rtl/spi_ctlr.sv
// Module: top of the SPI controller.
// Synchronises the slave-side pins, links the register file, the divider and
// the shift engine, and forms the output enables and the interrupt.
// Assumes that the slave-side pins are asynchronous to clk and that miso_i
// in master mode is timed by sck_o.
module spi_ctlr
    import spi_ctlr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              ss_n_i,
    output logic              irq
);
    localparam int NSYNC = 3;

    logic [NSYNC-1:0]  pin_raw, pin_s;
    logic              ie, en, mstr, sod, ss_int;
    logic [RATE_W-1:0] rate;
    logic              spif, wcol, ovr, modf;
    logic              load, tick, mbusy, busy, done, sdo;
    logic [DATA_W-1:0] load_data, rx_data;

    assign pin_raw = {ss_n_i, mosi_i, sck_i};

    // one synchroniser chain per slave-side pin
    for (genvar g = 0; g < NSYNC; g++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain;
        // shift the pin through the stages; select idles high
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= (g == NSYNC - 1) ? '1 : '0;
            else        chain <= {chain[SYNC_STAGES-2:0], pin_raw[g]};
        end
        assign pin_s[g] = chain[SYNC_STAGES-1];
    end

    spi_ctlr_regs #(.DATA_W(DATA_W), .RATE_W(RATE_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .done(done), .rx_data(rx_data), .busy(busy), .ss_pin_s(pin_s[2]),
        .ie(ie), .en(en), .mstr(mstr), .rate(rate), .sod(sod), .ss_int(ss_int),
        .spif(spif), .wcol(wcol), .ovr(ovr), .modf(modf),
        .load(load), .load_data(load_data)
    );

    spi_ctlr_clkdiv #(.RATE_W(RATE_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(mbusy), .rate(rate), .tick(tick)
    );

    spi_ctlr_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .en(en), .mstr(mstr), .sel(!ss_int),
        .tick(tick), .load(load), .load_data(load_data), .miso_i(miso_i),
        .sck_s(pin_s[0]), .mosi_s(pin_s[1]), .sck_o(sck_o), .sdo(sdo),
        .mbusy(mbusy), .busy(busy), .done(done), .rx_data(rx_data)
    );

    // pin drive, output enables and interrupt
    always_comb begin
        mosi_o  = sdo;
        miso_o  = sdo;
        sck_oe  = en && mstr;
        mosi_oe = en && mstr && !sod;
        miso_oe = en && !mstr && !sod && !ss_int;
        irq     = ie && (spif || ovr || modf);
    end
endmodule

// File: rtl/spi_ctlr_chk.sv
// Module: assertion checker for spi_ctlr, attached with bind.
// Assumes that the bound nets are the top-level flags and pin enables.
module spi_ctlr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_addr,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic       spif,
    input logic       wcol,
    input logic       ovr,
    input logic       modf,
    input logic       sod,
    input logic       done,
    input logic       busy,
    input logic       sck_oe,
    input logic       mosi_oe,
    input logic       miso_oe
);
    AST_SPIF_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spif) |-> $past(done)); // R2
    AST_SPIF_CLR_BY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spif) |-> $past((bus_rd || bus_wr) && bus_addr == 2'd2)); // R3
    AST_WCOL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wcol) |-> $past(busy)); // R4
    AST_OVR_NEEDS_SPIF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(spif)); // R5
    AST_MODF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(modf) |-> (!sck_oe && !mosi_oe)); // R6
    AST_MODF_CLR_BY_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(modf) |-> $past(bus_wr && bus_addr == 2'd0)); // R7
    AST_SOD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sod |-> (!mosi_oe && !miso_oe)); // R8
endmodule

bind spi_ctlr spi_ctlr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .spif(spif), .wcol(wcol), .ovr(ovr), .modf(modf),
    .sod(sod), .done(done), .busy(busy), .sck_oe(sck_oe),
    .mosi_oe(mosi_oe), .miso_oe(miso_oe)
);

// File: tb/sim_spi_ctlr.sv
// Bench for spi_ctlr: random master exchanges against a model slave,
// followed by directed cases for every flag sequence and the slave role.
module sim_spi_ctlr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;
    logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, irq;
    logic [7:0] bt_tx = '0, brx = '0;
    wire        miso_i = bt_tx[7];

    int tests = 0, fails = 0;

    always #2.5 clk = ~clk;

    spi_ctlr u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_i(mosi_i),
        .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_i(miso_i), .miso_o(miso_o),
        .miso_oe(miso_oe), .ss_n_i(ss_n_i), .irq(irq)
    );

    // model slave on the master's lines
    always @(posedge sck_o) brx <= {brx[6:0], mosi_o};
    always @(negedge sck_o) bt_tx <= {bt_tx[6:0], 1'b0};

    function automatic logic [7:0] stat_val(input logic f, w, o, m, d, s, i);
        return {f, w, o, m, 1'b0, d, s, i};
    endfunction

    function automatic logic [7:0] ctrl_val(input logic ie, en, ms, input logic [1:0] r);
        return {ie, en, 1'b0, ms, 2'b00, r};
    endfunction

    task automatic check(input string req, input logic [7:0] act, exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (!irq && n < 20000) begin @(negedge clk); n++; end
        check(req, {7'd0, irq}, 8'h01);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drive one byte as an external master into the slave port
    task automatic ext_byte(input logic [7:0] m, output logic [7:0] got);
        got = '0;
        for (int i = 7; i >= 0; i--) begin
            mosi_i = m[i]; idle(10);
            sck_i = 1'b1; got = {got[6:0], miso_o}; idle(10);
            sck_i = 1'b0;
        end
        idle(10);
    endtask

    initial begin
        int n = 0;
        while (n < 150000) begin @(posedge clk); n++; end
        fails++;
        $display("FAIL watchdog actual=%0d expected=done", n);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] d, tx, stx, got;
        logic [1:0] r;
        bit toggled;
        d = 8'h00;
        void'($urandom(32'h5A17));
        idle(3); rst_n = 1'b1; idle(2);

        // R1 reset state
        bread(2'd1, d); check("R1 status", d, 8'h00);
        bread(2'd0, d); check("R1 control", d, 8'h00);
        check("R1 pins", {4'd0, irq, sck_oe, mosi_oe, miso_oe}, 8'h00);

        // R2 random master exchanges
        for (int k = 0; k < 16; k++) begin
            r = 2'($urandom_range(0, 1));
            tx = 8'($urandom); stx = 8'($urandom);
            bwrite(2'd0, ctrl_val(1, 1, 1, r));
            bt_tx = stx;
            bwrite(2'd2, tx);
            wait_irq("R2 done");
            bread(2'd1, d); check("R2 status", d, stat_val(1, 0, 0, 0, 0, 0, 0));
            bread(2'd2, d); check("R2 rx byte", d, stx);
            check("R2 tx byte", brx, tx);
        end
        bread(2'd1, d); check("R3 cleared by data read", d, 8'h00);

        // R11 irq follows enable and flag
        bt_tx = 8'h3C; bwrite(2'd2, 8'hA5); wait_irq("R11 set");
        bwrite(2'd0, ctrl_val(0, 1, 1, 0)); idle(1);
        check("R11 masked", {7'd0, irq}, 8'h00);
        bwrite(2'd0, ctrl_val(1, 1, 1, 0));

        // R3 locked write is dropped
        bwrite(2'd2, 8'h77);
        toggled = 0;
        for (int i = 0; i < 60; i++) begin @(negedge clk); if (sck_o) toggled = 1; end
        check("R3 locked write no sck", {7'd0, toggled}, 8'h00);
        bread(2'd1, d); check("R3 still set", d, 8'h80);
        bt_tx = 8'hC3; bwrite(2'd2, 8'h5E); idle(2);
        bread(2'd1, d); check("R3 cleared by data write", d, 8'h00);
        wait_irq("R3 second xfer");
        check("R3 tx after unlock", brx, 8'h5E);
        bread(2'd1, d); bread(2'd2, d); check("R3 rx after unlock", d, 8'hC3);

        // R4 write collision at slow rate
        bwrite(2'd0, ctrl_val(1, 1, 1, 3));
        bt_tx = 8'h0F; bwrite(2'd2, 8'h96); idle(20);
        bwrite(2'd2, 8'h11);
        bread(2'd1, d); check("R4 wcol set", d, 8'h40);
        wait_irq("R4 done");
        check("R4 byte undisturbed", brx, 8'h96);
        bread(2'd1, d); check("R4 both flags", d, 8'hC0);
        bread(2'd2, d); check("R4 rx", d, 8'h0F);
        bread(2'd1, d); check("R4 cleared", d, 8'h00);

        // R8 output disable
        bwrite(2'd1, stat_val(0, 0, 0, 0, 1, 0, 0)); idle(1);
        check("R8 master oe", {6'd0, sck_oe, mosi_oe}, 8'h02);
        bwrite(2'd1, 8'h00);

        // R10 slave receive and transmit via pin select
        bwrite(2'd0, ctrl_val(0, 1, 0, 0));
        bwrite(2'd2, 8'hB2);
        ss_n_i = 1'b0; idle(10);
        check("R10 miso_oe", {7'd0, miso_oe}, 8'h01);
        ext_byte(8'h4D, got);
        check("R10 miso data", got, 8'hB2);
        bread(2'd1, d); check("R10 status", d, 8'h80);
        bread(2'd2, d); check("R10 rx", d, 8'h4D);

        // R5 overrun keeps the first byte
        ext_byte(8'h21, got);
        ext_byte(8'h9A, got);
        bread(2'd1, d); check("R5 overrun", d, 8'hA0);
        bread(2'd2, d); check("R5 buffer kept", d, 8'h21);
        bread(2'd1, d); check("R5 cleared", d, 8'h00);
        ss_n_i = 1'b1; idle(10);

        // R9 software select ignores the pin
        bwrite(2'd1, 8'h03); idle(2);
        ss_n_i = 1'b0; idle(10);
        ext_byte(8'h66, got);
        bread(2'd1, d); check("R9 deselected", d, 8'h03);
        ss_n_i = 1'b1;
        bwrite(2'd1, 8'h02); idle(10);
        ext_byte(8'hE7, got);
        bread(2'd1, d); check("R9 selected by level", d, 8'h82);
        bread(2'd2, d); check("R9 rx", d, 8'hE7);
        bwrite(2'd1, 8'h00); idle(10);

        // R6 mode fault, R7 clearing order
        bwrite(2'd0, ctrl_val(0, 1, 1, 0)); idle(5);
        check("R6 sck_oe before", {7'd0, sck_oe}, 8'h01);
        ss_n_i = 1'b0; idle(6);
        check("R6 released", {6'd0, sck_oe, mosi_oe}, 8'h00);
        ss_n_i = 1'b1; idle(6);
        bread(2'd0, d); check("R6 control cleared", d, ctrl_val(0, 0, 0, 0));
        bwrite(2'd0, 8'h00);
        bread(2'd1, d); check("R7 kept without status read", d, 8'h10);
        bwrite(2'd0, 8'h00);
        bread(2'd1, d); check("R7 cleared", d, 8'h00);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule